// File: doc/BRIEF.md
# Six-Output Edge-Programmable Pulse Generator

This block produces six pulse-width-modulated outputs from one up-counter that advances on every clock. Seven compare values drive it. Compare value 0 is the period limit: when the counter reaches it, the counter returns to zero, and that restart marks the start of the next cycle for all outputs. Compare values 1 to 6 place the output edges.

Each output works in one of two modes. In single-edge mode it is high from the cycle start until its own compare value is reached. In double-edge mode one compare value raises it and another lowers it, so each pulse can have its own position and its own width.

Software writes the compare values into a holding bank. The holding bank is copied to the working set only at a cycle restart, so a period in progress is never disturbed. One control word starts and stops the counter, selects the mode of each output, and gates each output pin.

Top module: `pwm_dual_edge`

## Requirements
- R1: While running, `count_o` steps by one per clock from 0 up to the working period limit (compare 0) and then returns to 0. A cycle therefore lasts limit+1 clocks, and a limit of 0 keeps the count at 0.
- R2: After reset, and while the run bit is 0, `count_o` is 0 and every bit of `pwm_o` is 0. Clearing the run bit takes effect at the next clock. Setting it restarts the outputs from count 0.
- R3: A single-edge output n (`pwm_o[n-1]`) is high while the count is below compare n and low from compare n up to the period limit. It is therefore high at count 0 whenever compare n is nonzero.
- R4: In single-edge mode, a compare n of 0 keeps output n low at all times. A compare n greater than the period limit keeps it high at all times.
- R5: A double-edge output n is raised at the count that equals compare n-1 and lowered at the count that equals compare n. Output 1 is raised at count 0, the cycle restart. Between those events the output keeps its level, across cycle boundaries as well.
- R6: When the raise and lower events of a double-edge output fall on the same count, the output is low at that count.
- R7: A compare value written while running has no effect until the first count-0 cycle after the next restart. While stopped, a written value becomes the working value one clock later.
- R8: Clearing the gate bit of output n holds `pwm_o[n-1]` low and does not stop that output's internal edge tracking. Setting the bit again shows the tracked level at once.
- R9: Register map: addresses 0 to 6 write compare values 0 to 6. Address 7 writes the control word: bit 0 is run, bit n (1..6) selects double-edge mode for output n (1 = double), and bit 6+n is the gate enable of output n (1 = driven).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the counter advances once per rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0..6 compare values, 7 control) |
| wr_data | input | 16 | Write data |
| pwm_o | output | 6 | PWM outputs; bit n-1 is output n |
| count_o | output | 16 | Current counter value |

## Verification
The bench targets the compare values at the edges of the range. A compare of zero must keep a single-edge output low; a design that compares with less-or-equal would instead emit a one-clock spike at each restart. A compare above the limit must keep the output high; a design that lowers the output at the wrap would instead show a short low slot. For double-edge outputs, the bench uses pulses that wrap across the restart and pairs whose raise and lower counts coincide; a design where the raise wins would hold such an output high. Compare values are rewritten mid-period to catch a design that updates its working values right away, which would cut the current cycle short. Outputs are gated off and back on to catch a design that resets the edge state when the gate closes.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

   typedef enum logic {
      EDGE_SINGLE = 1'b0,
      EDGE_DOUBLE = 1'b1
   } edge_mode_e;

   localparam int RUN_BIT = 0;

   // control word lives just above the compare bank
   function automatic int ctrl_addr(input int n_out);
      return n_out + 1;
   endfunction

   function automatic int addr_width(input int n_out);
      return $clog2(n_out + 2);
   endfunction

endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [CNT_W-1:0] limit,
   output logic [CNT_W-1:0] cnt,
   output logic             wrap,
   output logic             start
);

   assign wrap  = run && (cnt == limit);
   assign start = (cnt == '0);

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt <= '0;
      else if (!run || wrap)
         cnt <= '0;
      else
         cnt <= cnt + 1'b1;
   end

   // R1
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (cnt <= limit));

   // R2
   cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (cnt == '0));

endmodule

// File: rtl/pwm_regs.sv
module pwm_regs
   import pwm_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int N_OUT  = 6,
   parameter int ADDR_W = addr_width(N_OUT)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic [ADDR_W-1:0]             wr_addr,
   input  logic [CNT_W-1:0]              wr_data,
   input  logic                          wrap,
   output logic                          run,
   output logic [N_OUT-1:0]              dbl,
   output logic [N_OUT-1:0]              oe,
   output logic [N_OUT:0][CNT_W-1:0]     act
);

   localparam int N_CMP = N_OUT + 1;
   localparam int CTRL  = ctrl_addr(N_OUT);

   logic [N_OUT:0][CNT_W-1:0] shadow;
   logic                      load;

   assign load = !run || wrap;

   for (genvar k = 0; k < N_CMP; k++) begin : g_cmp
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            shadow[k] <= '0;
            act[k]    <= '0;
         end else begin
            if (load)
               act[k] <= shadow[k];
            if (wr_en && wr_addr == ADDR_W'(k))
               shadow[k] <= wr_data;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run <= 1'b0;
         dbl <= '0;
         oe  <= '0;
      end else if (wr_en && wr_addr == ADDR_W'(CTRL)) begin
         run <= wr_data[RUN_BIT];
         dbl <= wr_data[N_OUT:1];
         oe  <= wr_data[2*N_OUT:N_OUT+1];
      end
   end

   // R7
   act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !wrap) |=> $stable(act));

endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
   import pwm_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  edge_mode_e       mode,
   input  logic             oe,
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] clr_val,
   input  logic             set_hit,
   output logic             pin
);

   logic held_q;
   logic clr_hit;
   logic level;

   assign clr_hit = (cnt == clr_val);

   always_comb begin
      if (mode == EDGE_DOUBLE) begin
         if (clr_hit)      level = 1'b0;
         else if (set_hit) level = 1'b1;
         else              level = held_q;
      end else begin
         level = (cnt < clr_val);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         held_q <= 1'b0;
      else
         held_q <= run ? level : 1'b0;
   end

   assign pin = run && oe && level;

   // R2
   off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> !pin);

   // R6
   clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == EDGE_DOUBLE && cnt == clr_val) |-> !pin);

   // R4
   zero_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == EDGE_SINGLE && clr_val == '0) |-> !pin);

   // R3
   start_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && oe && mode == EDGE_SINGLE && cnt == '0 && clr_val != '0) |-> pin);

   // R8
   gate_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !oe |-> !pin);

endmodule

// File: rtl/pwm_dual_edge.sv
module pwm_dual_edge
   import pwm_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int N_OUT  = 6,
   parameter int ADDR_W = addr_width(N_OUT)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [CNT_W-1:0]  wr_data,
   output logic [N_OUT-1:0]  pwm_o,
   output logic [CNT_W-1:0]  count_o
);

   if (N_OUT < 1) begin : g_bad_nout
      $error("pwm_dual_edge: N_OUT must be at least 1");
   end
   if (CNT_W < 2*N_OUT + 1) begin : g_bad_width
      $error("pwm_dual_edge: CNT_W too narrow for the control word");
   end
   if (ADDR_W < addr_width(N_OUT)) begin : g_bad_addr
      $error("pwm_dual_edge: ADDR_W cannot reach the control word");
   end

   logic                      run;
   logic [N_OUT-1:0]          dbl;
   logic [N_OUT-1:0]          oe;
   logic [N_OUT:0][CNT_W-1:0] act;
   logic [CNT_W-1:0]          cnt;
   logic                      wrap;
   logic                      start;

   pwm_regs #(.CNT_W(CNT_W), .N_OUT(N_OUT), .ADDR_W(ADDR_W)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .wrap    (wrap),
      .run     (run),
      .dbl     (dbl),
      .oe      (oe),
      .act     (act)
   );

   pwm_timebase #(.CNT_W(CNT_W)) u_tb (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run),
      .limit (act[0]),
      .cnt   (cnt),
      .wrap  (wrap),
      .start (start)
   );

   for (genvar n = 1; n <= N_OUT; n++) begin : g_out
      logic set_hit;
      if (n == 1) begin : g_first
         // output 1 rises on the restart itself
         assign set_hit = start;
      end else begin : g_rest
         assign set_hit = (cnt == act[n-1]);
      end

      pwm_chan #(.CNT_W(CNT_W)) u_chan (
         .clk     (clk),
         .rst_n   (rst_n),
         .run     (run),
         .mode    (edge_mode_e'(dbl[n-1])),
         .oe      (oe[n-1]),
         .cnt     (cnt),
         .clr_val (act[n]),
         .set_hit (set_hit),
         .pin     (pwm_o[n-1])
      );
   end

   assign count_o = cnt;

endmodule

// File: tb/sim_pwm_dual_edge.sv
`timescale 1ns/1ps
module sim_pwm_dual_edge;

   localparam int CW = 16;
   localparam int NO = 6;
   localparam int AW = $clog2(NO + 2);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [CW-1:0] wr_data = '0;
   logic [NO-1:0] pwm_o;
   logic [CW-1:0] count_o;

   always #2.5 clk = ~clk;

   pwm_dual_edge #(.CNT_W(CW), .N_OUT(NO)) u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .pwm_o(pwm_o), .count_o(count_o)
   );

   typedef struct {
      int            cnt;
      logic [NO-1:0] pwm;
      string         tag;
   } item_t;

   item_t sbq[$];
   int    vectors = 0;
   int    misses  = 0;
   string phase   = "R2";
   bit    done    = 0;

   // reference state built from the requirements
   int          m_cnt;
   int          m_act [NO+1];
   int          m_sh  [NO+1];
   bit          m_run;
   bit [NO-1:0] m_dbl, m_oe, m_hq, nh;
   bit          wrapv;
   int          ncnt;

   function automatic bit lvl(input int n);
      bit rise;
      if (m_dbl[n-1]) begin
         rise = (n == 1) ? (m_cnt == 0) : (m_cnt == m_act[n-1]);
         if (m_cnt == m_act[n]) return 1'b0;   // R6 lower wins
         if (rise)              return 1'b1;
         return m_hq[n-1];
      end
      return m_cnt < m_act[n];
   endfunction

   // driver side of the scoreboard: expected item per clock
   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = 0; m_run = 0; m_dbl = '0; m_oe = '0; m_hq = '0;
         for (int k = 0; k <= NO; k++) begin m_act[k] = 0; m_sh[k] = 0; end
      end else begin
         item_t it;
         wrapv = m_run && (m_cnt == m_act[0]);
         for (int n = 1; n <= NO; n++) nh[n-1] = m_run ? lvl(n) : 1'b0;
         ncnt = (!m_run || wrapv) ? 0 : m_cnt + 1;
         if (!m_run || wrapv)
            for (int k = 0; k <= NO; k++) m_act[k] = m_sh[k];
         if (wr_en) begin
            if (int'(wr_addr) <= NO) m_sh[wr_addr] = int'(wr_data);
            else begin
               m_run = wr_data[0];
               m_dbl = wr_data[NO:1];
               m_oe  = wr_data[2*NO:NO+1];
            end
         end
         m_hq  = nh;
         m_cnt = ncnt;
         it.cnt = m_cnt;
         for (int n = 1; n <= NO; n++) it.pwm[n-1] = m_run & m_oe[n-1] & lvl(n);
         it.tag = phase;
         sbq.push_back(it);
      end
   end

   // monitor side: compare away from the active edge
   always @(negedge clk) begin
      if (sbq.size() > 0) begin
         item_t it;
         it = sbq.pop_front();
         vectors++;
         if (int'(count_o) != it.cnt || pwm_o !== it.pwm) begin
            misses++;
            $display("FAIL %s: count %0d pwm %b, expected count %0d pwm %b",
                     it.tag, count_o, pwm_o, it.cnt, it.pwm);
         end
      end
   end

   task automatic wr(input int addr, input int data);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = AW'(addr); wr_data = CW'(data);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic ctrl(input bit run, input bit [NO-1:0] dbl, input bit [NO-1:0] oe);
      wr(NO + 1, int'({oe, dbl, run}));
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic summary;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R2 reset state
      for (int i = 0; i < 2; i++) begin
         vectors++;
         if (count_o != '0 || pwm_o != '0) begin
            misses++;
            $display("FAIL R2: count %0d pwm %b, expected count 0 pwm 000000",
                     count_o, pwm_o);
         end
         @(negedge clk);
      end
      rst_n = 1'b1;

      // R9 map: compares written while stopped
      phase = "R9";
      wr(0, 9); wr(1, 3); wr(2, 0); wr(3, 12); wr(4, 9); wr(5, 5); wr(6, 7);
      phase = "R3";
      ctrl(1'b1, 6'b000000, 6'b111111);
      idle(25);
      phase = "R4";
      idle(12);
      // R7 mid-period rewrite
      phase = "R7";
      wr(3, 2); wr(5, 1);
      idle(25);
      // R1 shorter period
      phase = "R1";
      wr(0, 4);
      idle(16);
      wr(0, 0);
      idle(6);
      // R5 double-edge set
      phase = "R5";
      wr(0, 9); wr(1, 2); wr(2, 6); wr(3, 4); wr(4, 4); wr(5, 4); wr(6, 8);
      ctrl(1'b1, 6'b111111, 6'b111111);
      idle(30);
      phase = "R6";
      idle(12);
      // R8 gating
      phase = "R8";
      ctrl(1'b1, 6'b111111, 6'b101010);
      idle(17);
      ctrl(1'b1, 6'b111111, 6'b111111);
      idle(13);
      // R2 stop and restart
      phase = "R2";
      ctrl(1'b0, 6'b111111, 6'b111111);
      idle(6);
      ctrl(1'b1, 6'b010101, 6'b111111);
      phase = "R5";
      idle(30);
      done = 1;
      idle(2);
      summary();
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         misses++;
         $display("FAIL watchdog: run did not finish, expected completion");
         summary();
         $finish;
      end
   end

endmodule